// File: doc/BRIEF.md
# Flash Block Access Guard

This block sits between a flash request source and the flash engine. It splits the flash array into fixed-size blocks, 2 KB by default, and keeps two enable words: one read-permission bit and one write-permission bit per block. For each read, program or erase request it decides whether the request may pass. A permitted request goes on to the engine through a valid/ready stream. A refused request is consumed at once, is never forwarded, and raises a one-cycle error flag.

Two interrupt sources are tracked. One fires when the engine reports that a program or erase action has finished. The other fires when a program or erase request is refused because its block is write-protected. Software reads the raw status at any time, sets a mask, and reads the masked view. It clears events by writing ones to a clear register, and this clears both views at once.

The two most significant bits of the read-permission word are reserved for another purpose and are not block enables. Reads to the top two blocks are therefore always permitted.

Top module: `flash_guard`

## Requirements
- R1: The block index of a request is its byte address divided by 2048, which is address bits [15:11]. A read (kind 0) to a block among the lower NUM_BLOCKS-2 whose bit is 0 in the read-permission word (register offset 0) is refused. A read to such a block whose bit is 1 is forwarded.
- R2: Reads to the top two blocks (30 and 31) are forwarded whatever the value of bits 31:30 of the read-permission word.
- R3: A program (kind 1) or erase (kind 2) to a block whose bit is 0 in the write-permission word (offset 1) is refused. Reads to that block still follow the read-permission word.
- R4: A forwarded request appears on eng_valid, eng_addr and eng_kind in the same cycle, and req_ready equals eng_ready. A refused request has req_ready high whatever the value of eng_ready, and eng_valid stays low.
- R5: A refused handshake drives err high for exactly the next cycle.
- R6: A refused program or erase sets raw status bit 0, the access event. A refused read does not set it.
- R7: An eng_done pulse sets raw status bit 1, the completion event.
- R8: Raw status (offset 3) reads the same whatever the mask. The mask is at offset 2, bits [1:0]. Masked status (offset 4) is raw AND mask, and irq is the OR of the masked bits.
- R9: Writing 1 to a bit of the clear register (offset 5) clears that raw bit, and with it the masked bit. Writing 0 changes nothing. The clear register reads as zero.
- R10: When an event and a clear for the same bit fall in one cycle, the bit ends set.
- R11: Kind 3 is refused and does not set the access event.
- R12: After reset both permission words are all ones, the mask is 0, status is 0, and err and irq are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | 16 | Request byte address |
| req_kind | input | 2 | 0 read, 1 program, 2 erase, 3 reserved |
| eng_valid | output | 1 | Forwarded request valid |
| eng_ready | input | 1 | Engine accepts request |
| eng_addr | output | 16 | Forwarded address |
| eng_kind | output | 2 | Forwarded kind |
| eng_done | input | 1 | Program/erase completion pulse |
| err | output | 1 | One-cycle refusal flag |
| irq | output | 1 | Interrupt, OR of masked status |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational on reg_addr |

## Verification
The forwarding decision and req_ready are combinational, so the bench checks them in the same cycle in which it drives a request, shortly after applying it. The error flag, the status bits and irq change at the clock edge that ends the handshake, the done pulse or the write. The bench therefore samples them at the falling edge after that rising edge. It checks err again one cycle later to confirm the pulse has ended. Register reads are combinational on the offset and are sampled after the offset settles.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_PROG  = 2'd1,
    KIND_ERASE = 2'd2,
    KIND_RSVD  = 2'd3
  } req_kind_e;

  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] OFF_RDPERM = 3'd0;
  localparam logic [REG_AW-1:0] OFF_WRPERM = 3'd1;
  localparam logic [REG_AW-1:0] OFF_MASK   = 3'd2;
  localparam logic [REG_AW-1:0] OFF_RAW    = 3'd3;
  localparam logic [REG_AW-1:0] OFF_MSKD   = 3'd4;
  localparam logic [REG_AW-1:0] OFF_CLR    = 3'd5;

  localparam int EV_N    = 2;
  localparam int EV_ACC  = 0;
  localparam int EV_DONE = 1;
endpackage

// File: rtl/fbp_decide.sv
module fbp_decide import fbp_pkg::*; #(
  parameter int NUM_BLOCKS = 32,
  parameter int BLK_SH     = 11,
  parameter int RSVD_TOP   = 2,
  localparam int IDX_W     = $clog2(NUM_BLOCKS),
  localparam int ADDR_W    = IDX_W + BLK_SH
) (
  input  logic [ADDR_W-1:0]     addr,
  input  logic [1:0]            kind,
  input  logic [NUM_BLOCKS-1:0] rd_perm,
  input  logic [NUM_BLOCKS-1:0] wr_perm,
  output logic                  allow,
  output logic                  acc_viol
);
  logic [IDX_W-1:0]      blk;
  logic [NUM_BLOCKS-1:0] eff_rd;
  logic [BLK_SH-1:0]     unused_offset;

  assign blk           = addr[ADDR_W-1:BLK_SH];
  assign unused_offset = addr[BLK_SH-1:0];

  // Top RSVD_TOP bits of the read word carry no block meaning.
  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_eff
    if (i >= NUM_BLOCKS - RSVD_TOP) begin : g_fixed
      assign eff_rd[i] = 1'b1;
    end else begin : g_word
      assign eff_rd[i] = rd_perm[i];
    end
  end

  always_comb begin
    allow    = 1'b0;
    acc_viol = 1'b0;
    unique case (req_kind_e'(kind))
      KIND_READ:  allow = eff_rd[blk];
      KIND_PROG,
      KIND_ERASE: begin
        allow    = wr_perm[blk];
        acc_viol = !wr_perm[blk];
      end
      default:    allow = 1'b0;
    endcase
  end
endmodule

// File: rtl/fbp_status.sv
module fbp_status import fbp_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_N-1:0] set_ev,
  input  logic            clr_we,
  input  logic [EV_N-1:0] clr_bits,
  input  logic [EV_N-1:0] mask,
  output logic [EV_N-1:0] raw,
  output logic [EV_N-1:0] masked,
  output logic            irq
);
  logic [EV_N-1:0] clr_eff;

  assign clr_eff = clr_we ? clr_bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw <= '0;
    else        raw <= (raw & ~clr_eff) | set_ev;  // new event wins
  end

  assign masked = raw & mask;
  assign irq    = |masked;
endmodule

// File: rtl/flash_guard.sv
module flash_guard import fbp_pkg::*; #(
  parameter int NUM_BLOCKS  = 32,
  parameter int BLOCK_BYTES = 2048,
  parameter int RSVD_TOP    = 2,
  parameter int REG_W       = 32,
  localparam int BLK_SH     = $clog2(BLOCK_BYTES),
  localparam int ADDR_W     = $clog2(NUM_BLOCKS) + BLK_SH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_kind,
  output logic              eng_valid,
  input  logic              eng_ready,
  output logic [ADDR_W-1:0] eng_addr,
  output logic [1:0]        eng_kind,
  input  logic              eng_done,
  output logic              err,
  output logic              irq,
  input  logic              reg_wr,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata
);
  logic [NUM_BLOCKS-1:0] rd_perm_q, wr_perm_q;
  logic [EV_N-1:0]       mask_q, raw_st, masked_st, set_ev;
  logic                  allow, acc_viol, refused;

  fbp_decide #(
    .NUM_BLOCKS(NUM_BLOCKS), .BLK_SH(BLK_SH), .RSVD_TOP(RSVD_TOP)
  ) u_decide (
    .addr(req_addr), .kind(req_kind),
    .rd_perm(rd_perm_q), .wr_perm(wr_perm_q),
    .allow(allow), .acc_viol(acc_viol)
  );

  // Stream path: permitted requests pass straight through,
  // refused ones are swallowed without waiting on the engine.
  assign eng_valid = req_valid && allow;
  assign eng_addr  = req_addr;
  assign eng_kind  = req_kind;
  assign req_ready = allow ? eng_ready : 1'b1;
  assign refused   = req_valid && !allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err <= 1'b0;
    else        err <= refused;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_perm_q <= '1;
      wr_perm_q <= '1;
      mask_q    <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFF_RDPERM: rd_perm_q <= reg_wdata[NUM_BLOCKS-1:0];
        OFF_WRPERM: wr_perm_q <= reg_wdata[NUM_BLOCKS-1:0];
        OFF_MASK:   mask_q    <= reg_wdata[EV_N-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    set_ev          = '0;
    set_ev[EV_ACC]  = refused && acc_viol;
    set_ev[EV_DONE] = eng_done;
  end

  fbp_status u_status (
    .clk(clk), .rst_n(rst_n), .set_ev(set_ev),
    .clr_we(reg_wr && reg_addr == OFF_CLR),
    .clr_bits(reg_wdata[EV_N-1:0]), .mask(mask_q),
    .raw(raw_st), .masked(masked_st), .irq(irq)
  );

  always_comb begin
    case (reg_addr)
      OFF_RDPERM: reg_rdata = REG_W'(rd_perm_q);
      OFF_WRPERM: reg_rdata = REG_W'(wr_perm_q);
      OFF_MASK:   reg_rdata = REG_W'(mask_q);
      OFF_RAW:    reg_rdata = REG_W'(raw_st);
      OFF_MSKD:   reg_rdata = REG_W'(masked_st);
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/flash_guard_chk.sv
module flash_guard_chk import fbp_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [1:0]        req_kind,
  input logic              eng_valid,
  input logic              eng_ready,
  input logic              eng_done,
  input logic              err,
  input logic              irq,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic [1:0]        clr_lo,
  input logic [EV_N-1:0]   raw_st,
  input logic [EV_N-1:0]   mask_q
);
  // R4
  fwd_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_valid |-> req_valid);
  // R4
  backpress_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_valid && !eng_ready) |-> !req_ready);
  // R4
  refuse_no_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eng_valid) |-> req_ready);
  // R5
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eng_valid) |=> err);
  // R6
  acc_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !eng_valid && (req_kind == 2'd1 || req_kind == 2'd2))
    |=> raw_st[EV_ACC]);
  // R7
  done_sets_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |=> raw_st[EV_DONE]);
  // R9
  clear_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == OFF_CLR && clr_lo[EV_DONE] && !eng_done)
    |=> !raw_st[EV_DONE]);
  // R8
  mask_zero_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq);
endmodule

bind flash_guard flash_guard_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_kind(req_kind), .eng_valid(eng_valid), .eng_ready(eng_ready),
  .eng_done(eng_done), .err(err), .irq(irq), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .clr_lo(reg_wdata[1:0]), .raw_st(raw_st),
  .mask_q(mask_q)
);

// File: tb/flash_guard_bench.sv
module flash_guard_bench;
  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_ready;
  logic [15:0] req_addr = '0;
  logic [1:0]  req_kind = '0;
  logic        eng_valid, eng_ready = 1;
  logic [15:0] eng_addr;
  logic [1:0]  eng_kind;
  logic        eng_done = 0, err, irq;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  flash_guard u_flash_guard (.*);

  // {kind[1:0], addr[15:0], forwarded, access_event}
  localparam logic [19:0] VEC [11] = '{
    {2'd0, 16'h0000, 1'b1, 1'b0},  // R1 read blk0 allowed
    {2'd0, 16'h1800, 1'b0, 1'b0},  // R1 read blk3 refused
    {2'd1, 16'h1A00, 1'b1, 1'b0},  // R3 program blk3 allowed
    {2'd0, 16'h2800, 1'b1, 1'b0},  // R3 read blk5 still allowed
    {2'd1, 16'h2804, 1'b0, 1'b1},  // R3 program blk5 refused
    {2'd2, 16'h2FFF, 1'b0, 1'b1},  // R3 erase blk5 refused
    {2'd0, 16'hF800, 1'b1, 1'b0},  // R2 read blk31
    {2'd0, 16'hF000, 1'b1, 1'b0},  // R2 read blk30
    {2'd2, 16'h0010, 1'b1, 1'b0},  // R3 erase blk0 allowed
    {2'd3, 16'h0000, 1'b0, 1'b0},  // R11 reserved kind
    {2'd0, 16'h17FF, 1'b1, 1'b0}   // R1 last byte of blk2
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #0.5;
    d = reg_rdata;
  endtask

  initial begin
    logic [31:0] v;
    #1;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    // R12 reset state
    rd(3'd0, v); check("R12 read word", v, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R12 write word", v, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R12 mask", v, 0);
    rd(3'd3, v); check("R12 raw", v, 0);
    check("R12 err", err, 0);
    check("R12 irq", irq, 0);

    wr(3'd0, 32'h3FFF_FFF7);
    wr(3'd1, 32'hFFFF_FFDF);

    foreach (VEC[i]) begin
      @(negedge clk);
      req_kind = VEC[i][19:18]; req_addr = VEC[i][17:2]; req_valid = 1;
      #0.5;
      check($sformatf("R1 R2 R3 R11 fwd vec%0d", i), eng_valid, VEC[i][1]);
      check($sformatf("R4 ready vec%0d", i), req_ready, 1);
      if (VEC[i][1]) check($sformatf("R4 addr vec%0d", i), eng_addr, VEC[i][17:2]);
      @(negedge clk);
      req_valid = 0;
      check($sformatf("R5 err vec%0d", i), err, !VEC[i][1]);
      rd(3'd3, v);
      check($sformatf("R6 R11 raw vec%0d", i), v, {31'd0, VEC[i][0]});
      @(negedge clk);
      check($sformatf("R5 err ends vec%0d", i), err, 0);
      wr(3'd5, 32'h3);
    end

    // R4 back-pressure: allowed request waits, refused one does not
    @(negedge clk);
    eng_ready = 0; req_valid = 1; req_kind = 2'd0; req_addr = 16'h0000; #0.5;
    check("R4 held ready", req_ready, 0);
    check("R4 held valid", eng_valid, 1);
    req_addr = 16'h1800; #0.5;
    check("R4 refused ready", req_ready, 1);
    @(negedge clk); req_valid = 0; eng_ready = 1;
    rd(3'd3, v); check("R6 refused read no event", v, 0);

    // R7 / R8 completion and masking
    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(3'd3, v); check("R7 done raw", v, 2);
    rd(3'd4, v); check("R8 masked off", v, 0);
    check("R8 irq off", irq, 0);
    wr(3'd2, 32'h2);
    rd(3'd4, v); check("R8 masked on", v, 2);
    check("R8 irq on", irq, 1);
    rd(3'd3, v); check("R8 raw with mask", v, 2);

    // R9 clear behaviour
    wr(3'd5, 32'h0);
    rd(3'd3, v); check("R9 zero no effect", v, 2);
    rd(3'd5, v); check("R9 clear reads 0", v, 0);
    wr(3'd5, 32'h2);
    rd(3'd3, v); check("R9 raw cleared", v, 0);
    rd(3'd4, v); check("R9 masked cleared", v, 0);
    check("R9 irq cleared", irq, 0);

    // R10 event and clear in same cycle
    @(negedge clk);
    eng_done = 1; reg_wr = 1; reg_addr = 3'd5; reg_wdata = 32'h2;
    @(negedge clk);
    eng_done = 0; reg_wr = 0; reg_wdata = 0;
    rd(3'd3, v); check("R10 event wins", v, 2);
    check("R10 irq", irq, 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule